// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the periodic interrupt of a legacy real-time clock. It counts a 32.768 kHz tick strobe in a 15-bit free-running time base and raises an event whenever that count reaches a multiple of the selected period. The period is a power of two in ticks, chosen by a 4-bit rate code. A 3-bit divider-control field can let the time base run, freeze it, or hold it cleared.

Each event produces a one-cycle pulse. It also sets a sticky periodic flag and a level interrupt request. Both stay set until the surrounding register logic sends a clear-on-read pulse. Address decoding, time-of-day counting and alarms belong to neighbouring blocks.

Because events are tied to multiples of the period on the free-running count, a newly chosen rate fires on its next aligned boundary. It does not fire a fixed delay after the change.

Top module: `rtc_periodic_irq`

## Requirements
- R1: A synchronous active-low reset clears the time-base count, the pulse, the periodic flag and the interrupt request.
- R2: The time-base count advances by one on each cycle with `tick_32k` high, but only while `div_ctl` holds 0, 1 or 2. It wraps from 32767 to 0.
- R3: A `div_ctl` value of 6 or 7 forces the count to zero. Values 3, 4 and 5 freeze the count. In both cases no event occurs.
- R4: No event occurs while `rate_sel` is 0 or `per_en` is low.
- R5: For `rate_sel` from 3 to 15, the period is 2^(`rate_sel`-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R6: `rate_sel` 1 behaves as code 8 (128 ticks) and `rate_sel` 2 behaves as code 9 (256 ticks).
- R7: An event occurs on the tick that makes the count an exact multiple of the period, including the wrap to 0.
- R8: A change of `rate_sel` or `per_en` applies from the very next tick, with no restart of the count.
- R9: `per_pulse` is high for exactly the one cycle after the clock edge that sampled the boundary tick. `per_flag` and `irq` become set at that same edge.
- R10: `per_flag` and `irq` stay set until a `flag_clr` pulse clears them at the next edge. If `flag_clr` and an event arrive at the same edge, both stay set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe per 32.768 kHz period |
| div_ctl | input | 3 | Divider control: 0-2 run, 3-5 freeze, 6-7 hold cleared |
| rate_sel | input | 4 | Rate code; 0 disables |
| per_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Clear-on-read pulse for flag and request |
| per_pulse | output | 1 | One-cycle event pulse |
| per_flag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Level interrupt request |

## Verification
Every result of this block is due one edge after the tick, rate change or clear that causes it. That one cycle includes the count, the event pulse, and the setting or clearing of the flag and request. The bench drives inputs on the falling edge and keeps a behavioural model that advances on the rising edge. It compares all three outputs with the model on the following falling edge. Directed sequences count the ticks from a known count to the first pulse. This pins down alignment, aliasing, freeze and clear latencies to the exact tick.

// File: rtl/rtc_pi_pkg.sv
// Package: shared types and helpers for the RTC periodic interrupt generator.
// Assumes a 3-bit divider-control field whose encoding is fixed by the
// surrounding register block.
package rtc_pi_pkg;

    localparam int DIV_W = 3;

    typedef enum logic [1:0] {
        TB_RUN    = 2'd0,
        TB_FREEZE = 2'd1,
        TB_CLEAR  = 2'd2
    } tb_mode_e;

    // Classify the divider-control field: 0..2 run, 6..7 clear, others freeze.
    function automatic tb_mode_e decode_div(input logic [DIV_W-1:0] f);
        if (f <= DIV_W'(2))        return TB_RUN;
        else if (f[DIV_W-1:DIV_W-2] == 2'b11) return TB_CLEAR;
        else                        return TB_FREEZE;
    endfunction

endpackage

// File: rtl/rtc_pi_timebase.sv
// Module: free-running time base counting 32 kHz ticks.
// Counts accepted ticks modulo 2^CNT_W. Freezes or clears according to the
// divider mode. Exposes the value the count takes on an accepted tick so that
// boundary detection needs no extra cycle.
module rtc_pi_timebase
    import rtc_pi_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_ctl,
    output logic             adv,
    output logic [CNT_W-1:0] cnt_nxt
);

    tb_mode_e         mode;
    logic [CNT_W-1:0] cnt_q;

    // Decode the divider mode and qualify the incoming tick.
    always_comb begin
        mode    = decode_div(div_ctl);
        adv     = tick && (mode == TB_RUN);
        cnt_nxt = cnt_q + CNT_W'(1);
    end

    // Count register: cleared by reset or clear mode, stepped on accepted ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (mode == TB_CLEAR)  cnt_q <= '0;
        else if (adv)               cnt_q <= cnt_nxt;
    end

    // R3: clear mode empties the count by the next edge
    assert_clear_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TB_CLEAR) |=> (cnt_q == '0));

    // R2/R3: without an accepted tick the count holds (unless clearing)
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && mode != TB_CLEAR) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_pi_rate.sv
// Module: rate-code decoder.
// Maps the rate code to a low-bit mask of the period. Codes at or below
// ALIAS_LIMIT (except 0) are raised by ALIAS_ADD first. Assumes the largest
// effective code minus one is below CNT_W.
module rtc_pi_rate #(
    parameter int CODE_W      = 4,
    parameter int CNT_W       = 15,
    parameter int ALIAS_LIMIT = 2,
    parameter int ALIAS_ADD   = 7
) (
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              per_en,
    output logic              active,
    output logic [CNT_W-1:0]  mask
);

    localparam int SH_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] LIM_V = CODE_W'(ALIAS_LIMIT);
    localparam logic [SH_W-1:0]   ADD_V = SH_W'(ALIAS_ADD);

    logic [SH_W-1:0] eff_code;
    logic [SH_W-1:0] shift;

    // Apply the upward alias and derive the period exponent.
    always_comb begin
        active   = per_en && (rate_sel != '0);
        eff_code = {1'b0, rate_sel};
        if (rate_sel != '0 && rate_sel <= LIM_V)
            eff_code = {1'b0, rate_sel} + ADD_V;
        shift    = active ? (eff_code - SH_W'(1)) : '0;
    end

    // One mask bit per count bit: set when below the period exponent.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (SH_W'(i) < shift);
    end

endmodule

// File: rtl/rtc_pi_flags.sv
// Module: event pulse, sticky periodic flag and interrupt request.
// A boundary hit sets all three. A clear pulse drops the flag and the request
// unless a hit arrives at the same edge.
module rtc_pi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pulse_q,
    output logic flag_q,
    output logic irq_q
);

    // Register the pulse and update the sticky flag and request, set winning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (hit) begin
                flag_q <= 1'b1;
                irq_q  <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
                irq_q  <= 1'b0;
            end
        end
    end

    // R9/R10: a hit shows up at the next edge on all outputs, even with clr
    assert_hit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (pulse_q && flag_q && irq_q));

    // R10: request is held while no clear arrives
    assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr) |=> irq_q);

    // R10: a clear without a hit empties flag and request
    assert_clr_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> (!irq_q && !flag_q));

    // R9: the pulse lasts one cycle unless another hit follows
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !pulse_q);

endmodule

// File: rtl/rtc_periodic_irq.sv
// Module: RTC periodic interrupt generator (top).
// Fires an event when an accepted 32 kHz tick makes the free-running count a
// multiple of the selected power-of-two period. Assumes tick_32k is a
// single-cycle strobe synchronous to clk.
module rtc_periodic_irq
    import rtc_pi_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter int CODE_W      = 4,
    parameter int ALIAS_LIMIT = 2,
    parameter int ALIAS_ADD   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [DIV_W-1:0]  div_ctl,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              per_en,
    input  logic              flag_clr,
    output logic              per_pulse,
    output logic              per_flag,
    output logic              irq
);

    logic             adv;
    logic [CNT_W-1:0] cnt_nxt;
    logic             active;
    logic [CNT_W-1:0] mask;
    logic             hit;

    rtc_pi_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_32k),
        .div_ctl (div_ctl),
        .adv     (adv),
        .cnt_nxt (cnt_nxt)
    );

    rtc_pi_rate #(
        .CODE_W      (CODE_W),
        .CNT_W       (CNT_W),
        .ALIAS_LIMIT (ALIAS_LIMIT),
        .ALIAS_ADD   (ALIAS_ADD)
    ) u_rate (
        .rate_sel (rate_sel),
        .per_en   (per_en),
        .active   (active),
        .mask     (mask)
    );

    // Boundary: accepted tick lands the count on a multiple of the period.
    assign hit = adv && active && ((cnt_nxt & mask) == '0);

    rtc_pi_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (flag_clr),
        .pulse_q (per_pulse),
        .flag_q  (per_flag),
        .irq_q   (irq)
    );

    // R1: reset leaves every output clear
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!per_pulse && !per_flag && !irq));

    // R4: a pulse needs a tick, a non-zero code and the enable at the prior edge
    assert_pulse_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |-> $past(tick_32k && per_en && (rate_sel != '0)));

endmodule

// File: tb/rtc_periodic_irq_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed
// latency and pulse-count checks for each requirement.
module rtc_periodic_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [2:0] div_ctl = 3'd2;
    logic [3:0] rate_sel = 4'd0;
    logic       per_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       per_pulse, per_flag, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pc     = 0;

    // model state
    int m_cnt = 0;
    bit m_pulse = 0, m_flag = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    rtc_periodic_irq u_rtc_periodic_irq (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .div_ctl(div_ctl),
        .rate_sel(rate_sel), .per_en(per_en), .flag_clr(flag_clr),
        .per_pulse(per_pulse), .per_flag(per_flag), .irq(irq)
    );

    function automatic int period_of(input int c);
        if (c == 1) return 128;
        if (c == 2) return 256;
        return 1 << (c - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model, advanced on the rising edge.
    always @(posedge clk) begin
        bit adv, bnd;
        if (!rst_n) begin
            m_cnt = 0; m_pulse = 0; m_flag = 0; m_irq = 0;
        end else begin
            adv = tick_32k && (div_ctl <= 3'd2);
            if (div_ctl >= 3'd6) m_cnt = 0;
            else if (adv) m_cnt = (m_cnt + 1) % 32768;
            bnd = adv && (rate_sel != 0) && per_en &&
                  ((m_cnt % period_of(int'(rate_sel))) == 0);
            m_pulse = bnd;
            if (bnd) m_irq = 1;
            else if (flag_clr) m_irq = 0;
            m_flag = m_irq;
        end
    end

    // Lockstep comparison on the falling edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            check(per_pulse == m_pulse, "R9 pulse vs model", per_pulse, m_pulse);
            check(per_flag == m_flag && irq == m_irq, "R10 flag/irq vs model",
                  {per_flag, irq}, {m_flag, m_irq});
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 195000);
            summary();
        end
    end

    // One cycle: drive inputs, let an edge pass, sample at the falling edge.
    task automatic step(input bit t, input bit c = 1'b0);
        tick_32k = t;
        flag_clr = c;
        @(negedge clk);
        if (per_pulse) pc++;
        flag_clr = 1'b0;
    endtask

    // Ticks until first pulse, bounded.
    task automatic latency(input int limit, output int n);
        n = 0;
        pc = 0;
        while (pc == 0 && n < limit) begin
            step(1'b1);
            n++;
        end
    endtask

    task automatic zero_count();
        div_ctl = 3'd6;
        step(1'b1);
        div_ctl = 3'd2;
    endtask

    initial begin
        int n;
        int exp;
        @(negedge clk);
        step(1'b0); step(1'b0); step(1'b1);
        check(!per_pulse && !per_flag && !irq, "R1 reset state", {per_pulse, per_flag, irq}, 0);
        rst_n = 1'b1;

        // R5: code 3, tick every cycle, 64 ticks -> 16 pulses
        rate_sel = 4'd3; per_en = 1'b1; pc = 0;
        for (int i = 0; i < 64; i++) step(1'b1);
        check(pc == 16, "R5 code3 pulse count", pc, 16);

        // R10: request held, then cleared without a boundary
        for (int i = 0; i < 5; i++) step(1'b0);
        check(irq && per_flag, "R10 request held", irq, 1);
        step(1'b0, 1'b1);
        check(!irq && !per_flag, "R10 clear drops request", irq, 0);

        // R2: sparse ticks, every third cycle, 120 cycles -> 40 ticks -> 10 pulses
        zero_count(); pc = 0;
        for (int i = 0; i < 120; i++) step(i % 3 == 2);
        check(pc == 10, "R2 sparse tick count", pc, 10);

        // R7/R8: unaligned count, switch code 4 -> 5, first pulse on multiple of 16
        rate_sel = 4'd4;
        for (int i = 0; i < 3; i++) step(1'b1);
        rate_sel = 4'd5;
        exp = 16 - (m_cnt % 16);
        latency(40, n);
        check(n == exp, "R7 aligned first pulse after code change", n, exp);

        // R3: freeze keeps count, no pulses
        rate_sel = 4'd3;
        zero_count();
        step(1'b1); step(1'b1);
        div_ctl = 3'd4; pc = 0;
        for (int i = 0; i < 20; i++) step(1'b1);
        check(pc == 0, "R3 no pulse while frozen", pc, 0);
        div_ctl = 3'd2;
        latency(10, n);
        check(n == 2, "R3 frozen count resumes", n, 2);

        // R3: clear mode, then R6 code 1 -> 128 ticks
        div_ctl = 3'd7; pc = 0;
        for (int i = 0; i < 10; i++) step(1'b1);
        check(pc == 0, "R3 no pulse while cleared", pc, 0);
        div_ctl = 3'd2; rate_sel = 4'd1;
        latency(300, n);
        check(n == 128, "R6 code1 period", n, 128);

        // R6: code 2 -> 256 ticks between pulses
        rate_sel = 4'd2;
        zero_count();
        latency(600, n);
        check(n == 256, "R6 code2 first pulse", n, 256);
        latency(600, n);
        check(n == 256, "R6 code2 spacing", n, 256);

        // R4: code 0 with enable, and code 3 without enable
        step(1'b0, 1'b1);
        rate_sel = 4'd0; per_en = 1'b1; pc = 0;
        for (int i = 0; i < 300; i++) step(1'b1);
        check(pc == 0 && !irq, "R4 code zero silent", pc, 0);
        rate_sel = 4'd3; per_en = 1'b0; pc = 0;
        for (int i = 0; i < 40; i++) step(1'b1);
        check(pc == 0 && !irq, "R4 enable low silent", pc, 0);

        // R8: enabling applies at the next aligned tick
        per_en = 1'b1;
        exp = 4 - (m_cnt % 4);
        latency(10, n);
        check(n == exp, "R8 enable takes effect", n, exp);

        // R10: clear coinciding with a boundary keeps the request
        zero_count();
        step(1'b1); step(1'b1); step(1'b1);
        step(1'b1, 1'b1);
        check(irq && per_flag && per_pulse, "R10 set wins over clear", irq, 1);

        // R9: pulse lasts one cycle
        step(1'b0);
        check(!per_pulse && irq, "R9 single-cycle pulse", per_pulse, 0);

        // R1: mid-run reset clears outputs and the count
        rst_n = 1'b0;
        step(1'b1);
        check(!per_pulse && !per_flag && !irq, "R1 mid-run reset", irq, 0);
        rst_n = 1'b1;
        step(1'b1); step(1'b1);
        latency(10, n);
        check(n == 2, "R1 count cleared by reset", n, 2);

        // R5/R7/R2: code 15 over a full wrap, pulses at 16384 and at wrap
        rate_sel = 4'd15;
        zero_count();
        latency(20000, n);
        check(n == 16384, "R5 code15 period", n, 16384);
        latency(20000, n);
        check(n == 16384, "R7 boundary at wrap to zero", n, 16384);
        check(m_cnt == 0, "R2 count wrapped", m_cnt, 0);

        step(1'b0);
        summary();
    end

endmodule